// File: doc/BRIEF.md
# Two-Clock Shared-Array Memory with Selectable Read Latency

This block is a synchronous memory that two independent ports share. Each port has its own clock and can read or write any word of the common array at any time, including the same word that the other port is using. Each port captures its address, write data, lane enables and controls on its own clock edge. The 18-bit word is split into two 9-bit lanes that can be written separately.

A static per-port mode input picks the read path. The short path returns data one edge after the request is captured. The registered path adds a second output register and so one more edge of latency. Two chip enables of opposite polarity select a port, which lets several blocks share an address space without outside decode. A per-port sleep input makes the port ignore its dynamic inputs. An output enable blanks the data bus without touching any access.

When one port reads a word on the same edge that the other port writes it, the read returns the old contents.

Top module: `dpr_true_dual`

## Requirements
- R1: A write updates only the lanes whose enable is 1: lane enable bit 0 covers data bits 8:0 and bit 1 covers bits 17:9. With both enables 0, the word is unchanged.
- R2: With the mode input at 0 (short path), a read captured on edge E0 shows `Valid`=1 and its data on `Rdata` after edge E1, and until edge E2.
- R3: With the mode input at 1 (registered path), the same read shows `Valid`=0 after E1, and `Valid`=1 with its data after E2.
- R4: A port is selected only when `CeN`=0 and `Ce`=1. Any other combination performs no write and no read, and `Valid` stays 0.
- R5: A read captured on the edge just before the port is deselected is still delivered in its scheduled cycle. On the next edge `Valid` returns to 0, in both modes.
- R6: While `Sleep`=1, every dynamic input (address, data, lane enables, read/write, chip enables) is ignored: nothing is written and no read starts. A read already captured before sleep completes. The mode input and `Sleep` stay live.
- R7: `OutEn` acts combinationally on `Rdata` only. With `OutEn`=0, `Rdata` is zero while `Valid` still reports the read. Raising `OutEn` shows the data at once.
- R8: Both ports see one array, so a word written by one port is read back by the other. A read on the same edge as the other port's write to that word returns the old contents.
- R9: Only the low log2(DEPTH) address bits select a word. Addresses that differ only in the higher bits reach the same word.
- R10: During and right after reset, both ports show `Valid`=0 and `Rdata`=0.
- R11: Whenever `Valid`=0, `Rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for control and output registers |
| aClk | input | 1 | Port A clock |
| aSleep | input | 1 | Port A sleep: ignore dynamic inputs |
| aPipe | input | 1 | Port A read path: 1 registered, 0 short |
| aCeN | input | 1 | Port A chip enable, active low |
| aCe | input | 1 | Port A chip enable, active high |
| aRdWr | input | 1 | Port A direction: 1 read, 0 write |
| aByteEn | input | 2 | Port A lane write enables |
| aAddr | input | ADDR_W | Port A word address |
| aWdata | input | DATA_W | Port A write data |
| aOutEn | input | 1 | Port A output enable (combinational) |
| aRdata | output | DATA_W | Port A read data, zero when not driven |
| aValid | output | 1 | Port A read data valid |
| bClk | input | 1 | Port B clock |
| bSleep | input | 1 | Port B sleep: ignore dynamic inputs |
| bPipe | input | 1 | Port B read path: 1 registered, 0 short |
| bCeN | input | 1 | Port B chip enable, active low |
| bCe | input | 1 | Port B chip enable, active high |
| bRdWr | input | 1 | Port B direction: 1 read, 0 write |
| bByteEn | input | 2 | Port B lane write enables |
| bAddr | input | ADDR_W | Port B word address |
| bWdata | input | DATA_W | Port B write data |
| bOutEn | input | 1 | Port B output enable (combinational) |
| bRdata | output | DATA_W | Port B read data, zero when not driven |
| bValid | output | 1 | Port B read data valid |

## Verification
Two functions can land on the same edge: a write by one port and a read of the same word by the other. The bench drives both ports from clocks in phase and issues a port A write and a port B read of one address in the same cycle. It then judges B's data against the value held before the write. A second B read of that word must return the new value. A partial-lane write on one port followed by a read on the other checks that lane ownership is merged correctly across the two ports.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int LANES = 2;

  // strobes from a port's control to the shared datapath
  typedef struct packed {
    logic             wr;       // write the captured word this edge
    logic [LANES-1:0] lane;     // lanes to write
    logic             rd;       // load first output register this edge
    logic             ld2;      // load second output register this edge
    logic             usePipe;  // bus shows second register
    logic             drive;    // bus carries data (valid and enabled)
  } dprStb_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AW     = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              pipeMode,
  input  logic              ceN,
  input  logic              ce,
  input  logic              rdWr,
  input  logic [LANES-1:0]  byteEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              outEn,
  output dprStb_t           stb,
  output logic [AW-1:0]     addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic              rvalid
);
  logic             selQ, wrQ, v1, v2, outValid;
  logic [LANES-1:0] beQ;
  logic             unusedAddrHi;

  assign unusedAddrHi = ^addr[ADDR_W-1:AW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      wrQ    <= 1'b0;
      beQ    <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
    end else begin
      if (!sleep) begin
        selQ   <= ce & ~ceN;
        wrQ    <= ~rdWr;
        beQ    <= byteEn;
        addrQ  <= addr[AW-1:0];
        wdataQ <= wdata;
      end else begin
        selQ   <= 1'b0;
      end
      v1 <= selQ & ~wrQ;
      v2 <= v1;
    end
  end

  assign outValid    = pipeMode ? v2 : v1;
  assign rvalid      = outValid;
  assign stb.wr      = selQ & wrQ;
  assign stb.lane    = beQ;
  assign stb.rd      = selQ & ~wrQ;
  assign stb.ld2     = v1;
  assign stb.usePipe = pipeMode;
  assign stb.drive   = outValid & outEn;

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !(stb.wr || stb.rd)); // R6
  AST_SEL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || !ce) |=> !(stb.wr || stb.rd)); // R4
  AST_SHORT_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && rvalid) |-> $past(stb.rd)); // R2
  AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && rvalid) |-> $past(stb.rd, 2)); // R3
endmodule

// File: rtl/dpr_core.sv
`timescale 1ns/1ps
module dpr_core
  import dpr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 18,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = DATA_W / LANES
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  dprStb_t           stbA,
  input  logic [AW-1:0]     aIdx,
  input  logic [DATA_W-1:0] aWd,
  input  dprStb_t           stbB,
  input  logic [AW-1:0]     bIdx,
  input  logic [DATA_W-1:0] bWd,
  output logic [DATA_W-1:0] aRdata,
  output logic [DATA_W-1:0] bRdata
);
  logic [DATA_W-1:0] rdA, rdB, out1A, out2A, out1B, out2B;

  // Each lane keeps one copy per writing port and a pair of ownership
  // bits per word; equal bits mean port A wrote last, unequal mean B.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LW-1:0]    memA [DEPTH];
    logic [LW-1:0]    memB [DEPTH];
    logic [DEPTH-1:0] tagA, tagB;

    always_ff @(posedge clkA or negedge rstN) begin
      if (!rstN) tagA <= '0;
      else if (stbA.wr && stbA.lane[g]) tagA[aIdx] <= tagB[aIdx];
    end
    always_ff @(posedge clkA) begin
      if (stbA.wr && stbA.lane[g]) memA[aIdx] <= aWd[g*LW +: LW];
    end

    always_ff @(posedge clkB or negedge rstN) begin
      if (!rstN) tagB <= '0;
      else if (stbB.wr && stbB.lane[g]) tagB[bIdx] <= ~tagA[bIdx];
    end
    always_ff @(posedge clkB) begin
      if (stbB.wr && stbB.lane[g]) memB[bIdx] <= bWd[g*LW +: LW];
    end

    assign rdA[g*LW +: LW] = (tagA[aIdx] == tagB[aIdx]) ? memA[aIdx] : memB[aIdx];
    assign rdB[g*LW +: LW] = (tagA[bIdx] == tagB[bIdx]) ? memA[bIdx] : memB[bIdx];
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      out1A <= '0;
      out2A <= '0;
    end else begin
      if (stbA.rd)  out1A <= rdA;
      if (stbA.ld2) out2A <= out1A;
    end
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      out1B <= '0;
      out2B <= '0;
    end else begin
      if (stbB.rd)  out1B <= rdB;
      if (stbB.ld2) out2B <= out1B;
    end
  end

  assign aRdata = stbA.drive ? (stbA.usePipe ? out2A : out1A) : '0;
  assign bRdata = stbB.drive ? (stbB.usePipe ? out2B : out1B) : '0;
endmodule

// File: rtl/dpr_true_dual.sv
`timescale 1ns/1ps
module dpr_true_dual
  import dpr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              rstN,
  input  logic              aClk,
  input  logic              aSleep,
  input  logic              aPipe,
  input  logic              aCeN,
  input  logic              aCe,
  input  logic              aRdWr,
  input  logic [1:0]        aByteEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic              aOutEn,
  output logic [DATA_W-1:0] aRdata,
  output logic              aValid,
  input  logic              bClk,
  input  logic              bSleep,
  input  logic              bPipe,
  input  logic              bCeN,
  input  logic              bCe,
  input  logic              bRdWr,
  input  logic [1:0]        bByteEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic              bOutEn,
  output logic [DATA_W-1:0] bRdata,
  output logic              bValid
);
  localparam int AW = $clog2(DEPTH);

  dprStb_t           stbA, stbB;
  logic [AW-1:0]     aIdx, bIdx;
  logic [DATA_W-1:0] aWd, bWd;

  dpr_port_ctrl #(.ADDR_W(ADDR_W), .AW(AW), .DATA_W(DATA_W)) uCtrlA (
    .clk(aClk), .rstN(rstN), .sleep(aSleep), .pipeMode(aPipe), .ceN(aCeN),
    .ce(aCe), .rdWr(aRdWr), .byteEn(aByteEn), .addr(aAddr), .wdata(aWdata),
    .outEn(aOutEn), .stb(stbA), .addrQ(aIdx), .wdataQ(aWd), .rvalid(aValid));

  dpr_port_ctrl #(.ADDR_W(ADDR_W), .AW(AW), .DATA_W(DATA_W)) uCtrlB (
    .clk(bClk), .rstN(rstN), .sleep(bSleep), .pipeMode(bPipe), .ceN(bCeN),
    .ce(bCe), .rdWr(bRdWr), .byteEn(bByteEn), .addr(bAddr), .wdata(bWdata),
    .outEn(bOutEn), .stb(stbB), .addrQ(bIdx), .wdataQ(bWd), .rvalid(bValid));

  dpr_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uCore (
    .clkA(aClk), .clkB(bClk), .rstN(rstN),
    .stbA(stbA), .aIdx(aIdx), .aWd(aWd),
    .stbB(stbB), .bIdx(bIdx), .bWd(bWd),
    .aRdata(aRdata), .bRdata(bRdata));

  always_comb begin
    if (!(aValid && aOutEn)) AST_A_BUS_IDLE: assert (aRdata == '0); // R11
    if (!(bValid && bOutEn)) AST_B_BUS_IDLE: assert (bRdata == '0); // R7
  end
endmodule

// File: tb/sim_dpr_true_dual.sv
`timescale 1ns/1ps
module sim_dpr_true_dual;
  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  always #2.5 clkA = ~clkA;
  always #2.5 clkB = ~clkB;

  logic        sleep[2], pipe[2], ceN[2], ce[2], rdWr[2], oe[2];
  logic [1:0]  be[2];
  logic [11:0] addr[2];
  logic [17:0] wd[2];
  logic [17:0] rd[2];
  logic        vld[2];
  int nChk = 0, nBad = 0;

  dpr_true_dual u0 (
    .rstN(rstN),
    .aClk(clkA), .aSleep(sleep[0]), .aPipe(pipe[0]), .aCeN(ceN[0]), .aCe(ce[0]),
    .aRdWr(rdWr[0]), .aByteEn(be[0]), .aAddr(addr[0]), .aWdata(wd[0]),
    .aOutEn(oe[0]), .aRdata(rd[0]), .aValid(vld[0]),
    .bClk(clkB), .bSleep(sleep[1]), .bPipe(pipe[1]), .bCeN(ceN[1]), .bCe(ce[1]),
    .bRdWr(rdWr[1]), .bByteEn(be[1]), .bAddr(addr[1]), .bWdata(wd[1]),
    .bOutEn(oe[1]), .bRdata(rd[1]), .bValid(vld[1]));

  typedef struct packed {
    logic        p;
    logic        wr;
    logic        pm;
    logic [11:0] a;
    logic [17:0] d;
    logic [1:0]  b;
    logic [17:0] e;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 1'b0, 12'h005, 18'h3FFFF, 2'b11, 18'h0},
    '{1'b0, 1'b0, 1'b0, 12'h005, 18'h0,     2'b00, 18'h3FFFF}, // R2
    '{1'b1, 1'b1, 1'b0, 12'h005, 18'h00000, 2'b01, 18'h0},     // R1 lower lane, port B
    '{1'b0, 1'b0, 1'b1, 12'h005, 18'h0,     2'b00, 18'h3FE00}, // R8 R3
    '{1'b1, 1'b1, 1'b0, 12'h00A, 18'h12345, 2'b11, 18'h0},
    '{1'b1, 1'b1, 1'b0, 12'h00A, 18'h3FFFF, 2'b10, 18'h0},     // R1 upper lane
    '{1'b1, 1'b0, 1'b0, 12'h00A, 18'h0,     2'b00, 18'h3FF45},
    '{1'b0, 1'b1, 1'b0, 12'h40A, 18'h00001, 2'b11, 18'h0},     // R9 alias of 0x00A
    '{1'b1, 1'b0, 1'b1, 12'h00A, 18'h0,     2'b00, 18'h00001},
    '{1'b0, 1'b1, 1'b0, 12'h3FF, 18'h15555, 2'b11, 18'h0},
    '{1'b0, 1'b1, 1'b0, 12'h3FF, 18'h2AAAA, 2'b00, 18'h0},     // R1 no lanes
    '{1'b0, 1'b0, 1'b1, 12'h3FF, 18'h0,     2'b00, 18'h15555}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clkA);
  endtask

  task automatic setOp(input int p, input logic w, input logic [11:0] a,
                       input logic [17:0] d, input logic [1:0] b);
    ce[p] = 1'b1; ceN[p] = 1'b0; rdWr[p] = ~w; addr[p] = a; wd[p] = d; be[p] = b;
  endtask

  task automatic setIdle(input int p);
    ce[p] = 1'b0; ceN[p] = 1'b1; rdWr[p] = 1'b1; be[p] = 2'b00;
  endtask

  task automatic writeOp(input int p, input logic [11:0] a, input logic [17:0] d,
                         input logic [1:0] b);
    step(); setOp(p, 1'b1, a, d, b);
    step(); setIdle(p);
  endtask

  task automatic readChk(input int p, input logic [11:0] a, input logic [17:0] e,
                         input string req);
    step(); setOp(p, 1'b0, a, 18'h0, 2'b00);
    step(); setIdle(p);
    chk({req, " early valid"}, 32'(vld[p]), 32'd0);
    step();
    if (!pipe[p]) begin
      chk("R2 valid", 32'(vld[p]), 32'd1);
      chk({req, " data"}, 32'(rd[p]), 32'(e));
    end else begin
      chk("R3 valid held back", 32'(vld[p]), 32'd0);
      step();
      chk("R3 valid", 32'(vld[p]), 32'd1);
      chk({req, " data"}, 32'(rd[p]), 32'(e));
    end
    step();
    chk("R5 valid drop", 32'(vld[p]), 32'd0);
    chk("R11 idle bus", 32'(rd[p]), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clkA);
    nBad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      setIdle(p); sleep[p] = 1'b0; pipe[p] = 1'b0; oe[p] = 1'b1;
      addr[p] = '0; wd[p] = '0;
    end
    repeat (3) step();
    // R10: reset state during and after reset
    for (int p = 0; p < 2; p++) begin
      chk("R10 valid in reset", 32'(vld[p]), 32'd0);
      chk("R10 data in reset", 32'(rd[p]), 32'd0);
    end
    rstN = 1'b1;
    step(); step();
    for (int p = 0; p < 2; p++) begin
      chk("R10 valid after reset", 32'(vld[p]), 32'd0);
      chk("R10 data after reset", 32'(rd[p]), 32'd0);
    end

    // vector table walk
    for (int i = 0; i < 12; i++) begin
      if (VEC[i].wr) writeOp(int'(VEC[i].p), VEC[i].a, VEC[i].d, VEC[i].b);
      else begin
        pipe[VEC[i].p] = VEC[i].pm;
        readChk(int'(VEC[i].p), VEC[i].a, VEC[i].e, $sformatf("R1/R8/R9 vec%0d", i));
      end
    end

    // R4: both chip enables needed
    pipe[0] = 1'b0;
    writeOp(0, 12'h020, 18'h11111, 2'b11);
    step(); setOp(0, 1'b1, 12'h020, 18'h22222, 2'b11); ceN[0] = 1'b1;
    step(); setIdle(0);
    step(); setOp(0, 1'b1, 12'h020, 18'h33333, 2'b11); ce[0] = 1'b0;
    step(); setIdle(0);
    step(); setOp(0, 1'b0, 12'h020, 18'h0, 2'b00); ce[0] = 1'b0;
    step(); setIdle(0);
    step(); chk("R4 no read valid", 32'(vld[0]), 32'd0);
    step(); chk("R4 no read valid late", 32'(vld[0]), 32'd0);
    readChk(0, 12'h020, 18'h11111, "R4");

    // R6: sleep ignores dynamic inputs
    sleep[0] = 1'b1;
    step(); setOp(0, 1'b1, 12'h020, 18'h0ABCD, 2'b11);
    step(); setOp(0, 1'b0, 12'h020, 18'h0, 2'b00);
    step(); chk("R6 no read in sleep", 32'(vld[0]), 32'd0);
    step(); chk("R6 no read in sleep late", 32'(vld[0]), 32'd0);
    setIdle(0); sleep[0] = 1'b0;
    readChk(0, 12'h020, 18'h11111, "R6");
    // R6: read captured before sleep completes (registered path)
    pipe[0] = 1'b1;
    step(); setOp(0, 1'b0, 12'h020, 18'h0, 2'b00);
    step(); setIdle(0); sleep[0] = 1'b1;
    step();
    step(); chk("R6 inflight valid", 32'(vld[0]), 32'd1);
    chk("R6 inflight data", 32'(rd[0]), 32'h11111);
    sleep[0] = 1'b0;

    // R7: output enable blanks bus only
    pipe[0] = 1'b0; oe[0] = 1'b0;
    step(); setOp(0, 1'b0, 12'h020, 18'h0, 2'b00);
    step(); setIdle(0);
    step(); chk("R7 valid with oe low", 32'(vld[0]), 32'd1);
    chk("R7 bus blank", 32'(rd[0]), 32'd0);
    oe[0] = 1'b1; #1;
    chk("R7 bus after oe", 32'(rd[0]), 32'h11111);

    // R8: same-edge write on A and read on B of one word
    writeOp(0, 12'h030, 18'h00F0F, 2'b11);
    pipe[1] = 1'b0;
    step(); setOp(0, 1'b1, 12'h030, 18'h3C3C3, 2'b11); setOp(1, 1'b0, 12'h030, 18'h0, 2'b00);
    step(); setIdle(0); setIdle(1);
    step(); chk("R8 same-edge valid", 32'(vld[1]), 32'd1);
    chk("R8 same-edge old data", 32'(rd[1]), 32'h00F0F);
    readChk(1, 12'h030, 18'h3C3C3, "R8");

    step();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule